// File: doc/BRIEF.md
# UART FIFO Line Status Logic

This block keeps the transmit and receive character queues of a FIFO-capable serial port and derives the three upper bits of its line status byte from them: a receive error summary, a transmitter-idle flag and a transmit-ready flag. Each received character is stored together with three error tags (parity, framing, break). A counter tracks how many tagged characters are still queued, and the error summary stays set until the last of them has been popped. A read of the status byte does not clear it.

The same status drives three request lines. The receive DMA request follows the receive fill level against a programmable threshold and is held off while the error summary is set. The error interrupt fires only with DMA enabled. The transmit interrupt follows the transmit-ready flag. With FIFO operation turned off, each queue shrinks to a single holding register that a new write overwrites. Changing the FIFO mode flushes both queues.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset the status byte is 8'h60 (bit 7 error summary 0, bit 6 transmitter idle 1, bit 5 transmit ready 1, bits 4:0 always 0), and rx_dma_req, err_irq and tx_irq are 0 while their enables are 0.
- R2: In FIFO mode, status bit 7 is 1 exactly while at least one queued receive character carries a nonzero tag (rx tag bit 0 parity, bit 1 framing, bit 2 break). It clears in the cycle after the last tagged character is popped.
- R3: Pulsing status_rd never changes status bit 7.
- R4: With fifo_en low, status bit 7 reads 0 whatever tags are queued.
- R5: In FIFO mode the transmit queue holds TX_DEPTH characters in write order. A write while it is full is discarded, and the level and contents are unchanged.
- R6: Status bit 5 (transmit ready) is 1 exactly when the transmit queue is empty. It falls in the cycle after an accepted write and is 1 in the cycle after tx_fifo_clr, which empties the queue.
- R7: With fifo_en low, each queue is a single holding register. A write into a full holding register replaces its contents. Transmit ready clears on a write and sets when tx_load moves the character to the shifter.
- R8: Status bit 6 is 1 exactly when the transmit queue is empty and tx_shift_busy is 0.
- R9: rx_dma_req is dma_en AND (rx_level >= rx_trig in FIFO mode, rx_level >= 1 otherwise) AND NOT status bit 7.
- R10: err_irq is 1 exactly when dma_en is 1 and status bit 7 is 1.
- R11: tx_irq is 1 exactly when tx_ie is 1 and transmit ready is 1.
- R12: A receive push and pop in the same cycle keeps the tagged count exact. A push into a full FIFO-mode receive queue is discarded and its tag is not counted.
- R13: Any change of fifo_en empties both queues in the cycle after the change. A push made in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode select (0 = single holding registers) |
| dma_en | input | 1 | DMA request enable |
| tx_ie | input | 1 | Transmit-ready interrupt enable |
| status_rd | input | 1 | Status byte read strobe |
| tx_fifo_clr | input | 1 | Transmit queue clear |
| tx_wr | input | 1 | Transmit write strobe |
| tx_wdata | input | 8 | Transmit character |
| tx_load | input | 1 | Shifter takes the head transmit character |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| tx_rdata | output | 8 | Head transmit character |
| tx_level | output | $clog2(TX_DEPTH+1) | Transmit queue fill level |
| rx_push | input | 1 | Received character strobe |
| rx_wdata | input | 8 | Received character |
| rx_tag | input | 3 | Received error tags {break, framing, parity} |
| rx_pop | input | 1 | Receive queue read strobe |
| rx_trig | input | $clog2(RX_DEPTH+1) | Receive DMA threshold |
| rx_rdata | output | 8 | Head received character |
| rx_rtag | output | 3 | Tags of the head received character |
| rx_level | output | $clog2(RX_DEPTH+1) | Receive queue fill level |
| status | output | 8 | Line status byte |
| rx_dma_req | output | 1 | Receive DMA request |
| err_irq | output | 1 | Receive error interrupt |
| tx_irq | output | 1 | Transmit-ready interrupt |

## Verification
The bench uses the default depths of 16 for both queues, which is small enough to sweep fully. It places a single tagged character at each of the 16 receive positions with each of the three tag kinds and checks the error summary after every pop. The transmit side is written one character at a time, 18 in all, so every fill level and both overflow writes are covered. At these depths the DMA threshold boundary, same-cycle push and pop, the non-FIFO overwrite and the mode-change flush all take only a few cycles each.

// File: rtl/ustat_pkg.sv
package ustat_pkg;

    localparam int STAT_ERR  = 7;
    localparam int STAT_IDLE = 6;
    localparam int STAT_RDY  = 5;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_tag_t;

    localparam int TAG_W = $bits(rx_tag_t);

    function automatic logic tag_bad(input rx_tag_t t);
        return t.brk | t.frm | t.par;
    endfunction

endpackage

// File: rtl/ustat_fifo.sv
module ustat_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] level,
    output logic          take,
    output logic          drop
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t   st_d, st_q;
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cap;
    logic          full, pop_ok, push_ok, ovr;
    logic [AW-1:0] wr_addr;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap     = single ? CW'(1) : CW'(DEPTH);
        full    = (st_q.count >= cap);
        pop_ok  = pop && (st_q.count != '0);
        ovr     = single && push && full && !pop_ok;
        push_ok = push && (!full || pop_ok);
        take    = (push_ok || ovr) && !flush;
        drop    = (pop_ok || ovr) && !flush;
        wr_addr = ovr ? st_q.rd_ptr : st_q.wr_ptr;

        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (pop_ok)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            if (push_ok) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
            st_d.count = st_q.count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (take) mem[wr_addr] <= wdata;
    end

    assign rdata = mem[st_q.rd_ptr];
    assign level = st_q.count;

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !single && !flush && st_q.count == CW'(DEPTH))
        |=> (st_q.count == CW'(DEPTH)));

    assert_single_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (single && !flush) |=> (st_q.count <= CW'(1)));

endmodule

// File: rtl/ustat_err_count.sv
module ustat_err_count #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          add,
    input  logic          sub,
    input  logic [CW-1:0] level,
    output logic          nonzero
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) st_d.cnt = '0;
        else       st_d.cnt = st_q.cnt + CW'(add) - CW'(sub);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nonzero = (st_q.cnt != '0);

    assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sub |-> (st_q.cnt != '0));

    assert_tagged_within_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= level);

endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
    import ustat_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    localparam int TCW     = $clog2(TX_DEPTH + 1),
    localparam int RCW     = $clog2(RX_DEPTH + 1),
    localparam int RXW     = 8 + TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_en,
    input  logic             tx_ie,
    input  logic             status_rd,
    input  logic             tx_fifo_clr,
    input  logic             tx_wr,
    input  logic [7:0]       tx_wdata,
    input  logic             tx_load,
    input  logic             tx_shift_busy,
    output logic [7:0]       tx_rdata,
    output logic [TCW-1:0]   tx_level,
    input  logic             rx_push,
    input  logic [7:0]       rx_wdata,
    input  logic [TAG_W-1:0] rx_tag,
    input  logic             rx_pop,
    input  logic [RCW-1:0]   rx_trig,
    output logic [7:0]       rx_rdata,
    output logic [TAG_W-1:0] rx_rtag,
    output logic [RCW-1:0]   rx_level,
    output logic [7:0]       status,
    output logic             rx_dma_req,
    output logic             err_irq,
    output logic             tx_irq
);

    typedef struct packed {
        logic fifo_en;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       mode_chg, tx_flush;
    logic       tx_take, tx_drop, rx_take, rx_drop;
    logic [RXW-1:0] rx_head;
    logic       err_nz, err_bit, idle_bit, rdy_bit;
    logic [RCW-1:0] eff_trig;

    always_comb begin
        st_d         = st_q;
        st_d.fifo_en = fifo_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_chg = (fifo_en != st_q.fifo_en);
    assign tx_flush = mode_chg || tx_fifo_clr;

    ustat_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .single(!fifo_en),
        .push  (tx_wr),
        .wdata (tx_wdata),
        .pop   (tx_load),
        .rdata (tx_rdata),
        .level (tx_level),
        .take  (tx_take),
        .drop  (tx_drop)
    );

    ustat_fifo #(.W(RXW), .DEPTH(RX_DEPTH)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (mode_chg),
        .single(!fifo_en),
        .push  (rx_push),
        .wdata ({rx_tag, rx_wdata}),
        .pop   (rx_pop),
        .rdata (rx_head),
        .level (rx_level),
        .take  (rx_take),
        .drop  (rx_drop)
    );

    assign rx_rdata = rx_head[7:0];
    assign rx_rtag  = rx_head[RXW-1:8];

    ustat_err_count #(.DEPTH(RX_DEPTH)) u_err_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (mode_chg),
        .add    (rx_take && tag_bad(rx_tag_t'(rx_tag))),
        .sub    (rx_drop && tag_bad(rx_tag_t'(rx_rtag))),
        .level  (rx_level),
        .nonzero(err_nz)
    );

    always_comb begin
        err_bit  = fifo_en && err_nz;
        rdy_bit  = (tx_level == '0);
        idle_bit = rdy_bit && !tx_shift_busy;
        eff_trig = fifo_en ? rx_trig : RCW'(1);

        status            = '0;
        status[STAT_ERR]  = err_bit;
        status[STAT_IDLE] = idle_bit;
        status[STAT_RDY]  = rdy_bit;

        rx_dma_req = dma_en && (rx_level >= eff_trig) && (rx_level != '0) && !err_bit;
        err_irq    = dma_en && err_bit;
        tx_irq     = tx_ie && rdy_bit;
    end

    assert_rdy_falls_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !tx_flush) |=> !status[STAT_RDY]);

    assert_idle_implies_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_IDLE] |-> status[STAT_RDY]);

    assert_read_keeps_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !rx_pop && !mode_chg && status[STAT_ERR]) |=> status[STAT_ERR]);

    assert_tagged_push_sets_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !mode_chg && rx_take && tag_bad(rx_tag_t'(rx_tag))) |=> status[STAT_ERR]);

    assert_flush_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (tx_level == '0 && rx_level == '0));

endmodule

// File: tb/uart_fifo_status_bench.sv
module uart_fifo_status_bench;

    localparam int TXD = 16;
    localparam int RXD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, dma_en = 1'b0, tx_ie = 1'b0, status_rd = 1'b0;
    logic       tx_fifo_clr = 1'b0, tx_wr = 1'b0, tx_load = 1'b0, tx_shift_busy = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic [7:0] tx_rdata;
    logic [4:0] tx_level;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0;
    logic [2:0] rx_tag = '0;
    logic [4:0] rx_trig = 5'd1;
    logic [7:0] rx_rdata;
    logic [2:0] rx_rtag;
    logic [4:0] rx_level;
    logic [7:0] status;
    logic       rx_dma_req, err_irq, tx_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    uart_fifo_status #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_uart_fifo_status (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en), .tx_ie(tx_ie),
        .status_rd(status_rd), .tx_fifo_clr(tx_fifo_clr), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .tx_load(tx_load), .tx_shift_busy(tx_shift_busy),
        .tx_rdata(tx_rdata), .tx_level(tx_level), .rx_push(rx_push),
        .rx_wdata(rx_wdata), .rx_tag(rx_tag), .rx_pop(rx_pop), .rx_trig(rx_trig),
        .rx_rdata(rx_rdata), .rx_rtag(rx_rtag), .rx_level(rx_level),
        .status(status), .rx_dma_req(rx_dma_req), .err_irq(err_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rx_put(input int d, input int t);
        rx_push = 1'b1; rx_wdata = 8'(d); rx_tag = 3'(t);
        cyc();
        rx_push = 1'b0; rx_tag = '0;
    endtask

    task automatic rx_take();
        rx_pop = 1'b1;
        cyc();
        rx_pop = 1'b0;
    endtask

    task automatic tx_put(input int d);
        tx_wr = 1'b1; tx_wdata = 8'(d);
        cyc();
        tx_wr = 1'b0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected 0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 status", status, 8'h60);
        chk("R1 dma", rx_dma_req, 0);
        chk("R1 err_irq", err_irq, 0);
        chk("R1 tx_irq", tx_irq, 0);
        tx_ie = 1'b1;
        #1 chk("R11 tx_irq ready", tx_irq, 1);

        fifo_en = 1'b1;
        cyc(); cyc();

        // R5 R6 R8: fill sweep past capacity
        for (int n = 1; n <= TXD + 2; n++) begin
            tx_put(n);
            chk("R5 level", tx_level, (n < TXD) ? n : TXD);
            chk("R6 ready low", status[5], 0);
            chk("R8 idle low", status[6], 0);
            chk("R11 tx_irq low", tx_irq, 0);
        end
        for (int n = 1; n <= TXD; n++) begin
            chk("R5 order", tx_rdata, n);
            tx_load = 1'b1; cyc(); tx_load = 1'b0;
        end
        chk("R6 ready after drain", status[5], 1);
        chk("R8 idle", status[6], 1);
        tx_shift_busy = 1'b1;
        #1 chk("R8 busy", status[6], 0);
        tx_shift_busy = 1'b0;
        for (int n = 0; n < 3; n++) tx_put(n);
        tx_fifo_clr = 1'b1; cyc(); tx_fifo_clr = 1'b0;
        chk("R6 clr level", tx_level, 0);
        chk("R6 clr ready", status[5], 1);

        // R2 R3: one tagged character at each position, each tag kind
        status_rd = 1'b1;
        for (int kind = 0; kind < 3; kind++) begin
            for (int pos = 0; pos < RXD; pos++) begin
                for (int i = 0; i < RXD; i++) rx_put(i, (i == pos) ? (1 << kind) : 0);
                chk("R2 set", status[7], 1);
                for (int k = 1; k <= RXD; k++) begin
                    chk("R2 head", rx_rdata, k - 1);
                    chk("R2 head tag", rx_rtag, (k - 1 == pos) ? (1 << kind) : 0);
                    rx_take();
                    chk("R2 R3 err after pop", status[7], (pos >= k) ? 1 : 0);
                end
            end
        end
        rx_put(7, 3'b010);
        repeat (3) cyc();
        chk("R3 read held", status[7], 1);
        status_rd = 1'b0;

        // R12 same-cycle push and pop
        rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 8'd9; rx_tag = 3'b100;
        cyc();
        rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 8'd10; rx_tag = 3'b000;
        chk("R12 swap tagged", status[7], 1);
        cyc();
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R12 swap clean", status[7], 0);
        chk("R12 level", rx_level, 1);
        rx_take();
        for (int i = 0; i < RXD; i++) rx_put(i, 0);
        rx_put(99, 3'b001);
        chk("R12 full drop err", status[7], 0);
        chk("R12 full level", rx_level, RXD);
        for (int i = 0; i < RXD; i++) rx_take();

        // R9 R10 threshold and error gating
        dma_en = 1'b1; rx_trig = 5'd4;
        for (int i = 0; i < 3; i++) rx_put(i, 0);
        chk("R9 below trig", rx_dma_req, 0);
        rx_put(3, 0);
        chk("R9 at trig", rx_dma_req, 1);
        rx_put(4, 3'b001);
        chk("R9 err blocks", rx_dma_req, 0);
        chk("R10 err_irq dma", err_irq, 1);
        dma_en = 1'b0;
        #1 chk("R10 err_irq no dma", err_irq, 0);

        // R13 mode change flush
        tx_put(5);
        fifo_en = 1'b0;
        cyc();
        chk("R13 rx flushed", rx_level, 0);
        chk("R13 tx flushed", tx_level, 0);

        // R4 R7 non-FIFO
        rx_put(21, 3'b100);
        chk("R4 err forced 0", status[7], 0);
        rx_put(22, 3'b000);
        chk("R7 rx overwrite", rx_rdata, 22);
        chk("R7 rx level", rx_level, 1);
        dma_en = 1'b1;
        #1 chk("R9 single dma", rx_dma_req, 1);
        dma_en = 1'b0;
        tx_put(31);
        chk("R7 ready clears", status[5], 0);
        tx_put(32);
        chk("R7 tx overwrite", tx_rdata, 32);
        chk("R7 tx level", tx_level, 1);
        tx_load = 1'b1; cyc(); tx_load = 1'b0;
        chk("R7 ready on load", status[5], 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule